// File: doc/BRIEF.md
# Auto-Increment Indirect Buffer Access Port

This block gives a host indirect access to a 2 KB on-chip packet buffer through a small window of I/O registers. The host first writes a buffer address into two pointer registers. It then reads or writes a single data port, and each data access goes to the buffer location the pointer names. The host does not need a large memory-mapped window this way.

When the auto-increment enable is set, the pointer advances once each data access has finished. A whole packet can then be streamed through the data port without reloading the address. The host can use 8-bit or 16-bit accesses. In byte mode the pointer steps by one. In word mode it steps by two, and the word lies at the even address.

Each host access is a strobe, `host_sel`, which may stay high for one or more clock cycles. Pointer loads and buffer writes take effect on the first clock edge of the strobe. The pointer step takes effect on the edge that follows the end of the strobe. Read data is combinational, so it is valid in the same cycle as the strobe.

Top module: `seq_ram_port`

## Requirements
- R1: After reset the pointer is 0 and auto-increment is off, so reads of offsets 0Eh and 0Fh return 0.
- R2: A write to offset 0Eh loads pointer bits 7:0 from wdata[7:0]. A write to offset 0Fh loads pointer bits 10:8 from wdata[2:0] and the auto-increment enable from wdata[6]. A read of 0Fh returns {1'b0, enable, 3'b000, pointer[10:8]}, a read of 0Eh returns pointer[7:0], and both are zero-extended to 16 bits.
- R3: Writing either pointer register never advances the pointer.
- R4: With word_mode low, the data port is offset 0Ch. A write stores wdata[7:0] at the byte the pointer names. A read returns {8'h00, byte} in the same cycle as the strobe.
- R5: With word_mode high, a data-port access at 0Ch moves 16 bits. The low byte is at the even address and the high byte at the odd address.
- R6: With auto-increment on, the pointer advances by 1 (byte mode) or 2 (word mode) on the clock edge after the data-port strobe ends.
- R7: With auto-increment off, data-port accesses leave the pointer unchanged.
- R8: The pointer wraps modulo 2048.
- R9: While a data strobe is held over several cycles, the pointer does not move. Each strobe causes exactly one step.
- R10: Offset 0Dh and every offset other than 0Ch, 0Eh and 0Fh read as 0. Writes to them change neither the pointer nor the buffer.
- R11: A word-mode access with an odd pointer uses the word at the pointer with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit host accesses, 0: 8-bit |
| host_sel | input | 1 | Access strobe, one or more cycles |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register offset in the window |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational, zero when not reading |

## Verification
The assertions assume that `host_addr`, `host_wr` and `word_mode` stay constant for the whole of a strobe. They also assume that `host_sel` stays low while reset is applied. The pointer-step properties compare the previous cycle's address with the data offset, so they rely on these inputs not changing between the last strobe cycle and the falling edge of the strobe. The bench drives every input on the falling clock edge and changes them only while `host_sel` is low. Between any two accesses it keeps the strobe low for at least one clock edge.

// File: rtl/seq_ram_port_pkg.sv
package seq_ram_port_pkg;
  localparam logic [3:0] OFS_DATA = 4'hC;
  localparam logic [3:0] OFS_PLO  = 4'hE;
  localparam logic [3:0] OFS_PHI  = 4'hF;
  localparam int         AIE_BIT  = 6;

  typedef struct packed {
    logic data;
    logic plo;
    logic phi;
  } acc_sel_t;
endpackage

// File: rtl/seq_ram_port_decode.sv
module seq_ram_port_decode
  import seq_ram_port_pkg::*;
(
  input  logic [3:0] addr,
  output acc_sel_t   sel
);
  always_comb begin
    sel      = '0;
    sel.data = (addr == OFS_DATA);
    sel.plo  = (addr == OFS_PLO);
    sel.phi  = (addr == OFS_PHI);
  end
endmodule

// File: rtl/seq_ram_port_ptr.sv
module seq_ram_port_ptr #(
  parameter int PTR_W = 11,
  localparam int HI_W = PTR_W - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_lo,
  input  logic             load_hi,
  input  logic [7:0]       lo_in,
  input  logic [HI_W-1:0]  hi_in,
  input  logic             aie_in,
  input  logic             step_en,
  input  logic             step_word,
  output logic [PTR_W-1:0] ptr,
  output logic             aie
);
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             aie_q, aie_n;
  logic [PTR_W-1:0] step;

  assign step = {{(PTR_W-2){1'b0}}, step_word, ~step_word};

  always_comb begin
    ptr_n = ptr_q;
    aie_n = aie_q;
    if (load_lo) ptr_n[7:0] = lo_in;
    if (load_hi) begin
      ptr_n[PTR_W-1:8] = hi_in;
      aie_n            = aie_in;
    end
    if (step_en) ptr_n = ptr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      aie_q <= 1'b0;
    end else if (load_lo || load_hi || step_en) begin
      ptr_q <= ptr_n;
      aie_q <= aie_n;
    end
  end

  assign ptr = ptr_q;
  assign aie = aie_q;
endmodule

// File: rtl/seq_ram_port_mem.sv
module seq_ram_port_mem #(
  parameter int PTR_W = 11,
  localparam int WA_W  = PTR_W - 1,
  localparam int DEPTH = 1 << WA_W
) (
  input  logic            clk,
  input  logic            we,
  input  logic [1:0]      be,
  input  logic [WA_W-1:0] waddr,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata
);
  logic [15:0] mem [DEPTH];

  for (genvar b = 0; b < 2; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && be[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = mem[waddr];
endmodule

// File: rtl/seq_ram_port.sv
module seq_ram_port
  import seq_ram_port_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata
);
  localparam int HI_W = PTR_W - 8;
  localparam int PAD_W = AIE_BIT - HI_W;

  logic       rst_meta_q, rst_sync_n;
  logic       stb_q, acc_data_q, acc_word_q;
  logic       stb_rise, stb_fall;
  acc_sel_t   dsel;
  logic [PTR_W-1:0] ptr_q;
  logic       aie_q;
  logic [15:0] mem_rdata, mem_wdata;
  logic [1:0] mem_be;
  logic       mem_we;
  logic [7:0] byte_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_ram_port_decode i_dec (.addr(host_addr), .sel(dsel));

  assign stb_rise = host_sel && !stb_q;
  assign stb_fall = !host_sel && stb_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stb_q      <= 1'b0;
      acc_data_q <= 1'b0;
      acc_word_q <= 1'b0;
    end else begin
      stb_q <= host_sel;
      if (stb_rise) begin
        acc_data_q <= dsel.data;
        acc_word_q <= word_mode;
      end
    end
  end

  seq_ram_port_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_lo   (stb_rise && host_wr && dsel.plo),
    .load_hi   (stb_rise && host_wr && dsel.phi),
    .lo_in     (host_wdata[7:0]),
    .hi_in     (host_wdata[HI_W-1:0]),
    .aie_in    (host_wdata[AIE_BIT]),
    .step_en   (stb_fall && acc_data_q && aie_q),
    .step_word (acc_word_q),
    .ptr       (ptr_q),
    .aie       (aie_q)
  );

  assign mem_we    = stb_rise && host_wr && dsel.data;
  assign mem_be    = word_mode ? 2'b11 : (ptr_q[0] ? 2'b10 : 2'b01);
  assign mem_wdata = word_mode ? host_wdata : {host_wdata[7:0], host_wdata[7:0]};

  seq_ram_port_mem #(.PTR_W(PTR_W)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .be    (mem_be),
    .waddr (ptr_q[PTR_W-1:1]),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign byte_rd = ptr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_wr) begin
      if (dsel.data)     host_rdata = word_mode ? mem_rdata : {8'h00, byte_rd};
      else if (dsel.plo) host_rdata = {8'h00, ptr_q[7:0]};
      else if (dsel.phi) host_rdata = {8'h00, 1'b0, aie_q, {PAD_W{1'b0}}, ptr_q[PTR_W-1:8]};
    end
  end
endmodule

// File: rtl/seq_ram_port_chk.sv
module seq_ram_port_chk
  import seq_ram_port_pkg::*;
#(
  parameter int PTR_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_mode,
  input logic             host_sel,
  input logic             host_wr,
  input logic [3:0]       host_addr,
  input logic [15:0]      host_rdata,
  input logic [PTR_W-1:0] ptr,
  input logic             aie
);
  logic unmapped;
  assign unmapped = (host_addr != OFS_DATA) && (host_addr != OFS_PLO) && (host_addr != OFS_PHI);

  AST_PTR_STILL_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && $past(host_sel) |=> $stable(ptr)); // R9

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel && $past(host_sel) && $past(host_addr) == OFS_DATA && aie && !$past(word_mode)
    |=> ptr == $past(ptr) + PTR_W'(1)); // R6

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel && $past(host_sel) && $past(host_addr) == OFS_DATA && aie && $past(word_mode)
    |=> ptr == $past(ptr) + PTR_W'(2)); // R6

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel && $past(host_sel) && $past(host_addr) == OFS_DATA && !aie
    |=> $stable(ptr)); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && !host_wr && unmapped |-> host_rdata == 16'h0000); // R10

  AST_BYTE_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && !host_wr && !word_mode |-> host_rdata[15:8] == 8'h00); // R4
endmodule

bind seq_ram_port seq_ram_port_chk #(.PTR_W(PTR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .word_mode  (word_mode),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .ptr        (ptr_q),
  .aie        (aie_q)
);

// File: tb/test_seq_ram_port.sv
module test_seq_ram_port;
  logic        clk;
  logic        rst_n;
  logic        word_mode;
  logic        host_sel;
  logic        host_wr;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  seq_ram_port i_seq_ram_port (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .host_sel(host_sel),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        word;
    logic [3:0]  off;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,4'hF,16'h0041,16'h0000,4'd2},  // R2 aie on, hi=1
    '{1'b1,1'b0,4'hE,16'h00FE,16'h0000,4'd2},  // R2 ptr=1FE
    '{1'b0,1'b0,4'hF,16'h0000,16'h0041,4'd2},  // R2 readback
    '{1'b0,1'b0,4'hE,16'h0000,16'h00FE,4'd3},  // R3 no step on loads
    '{1'b1,1'b0,4'hC,16'h00AA,16'h0000,4'd4},  // R4 byte 1FE
    '{1'b1,1'b0,4'hC,16'h0055,16'h0000,4'd4},  // R4 byte 1FF
    '{1'b0,1'b0,4'hE,16'h0000,16'h0000,4'd6},  // R6 ptr=200
    '{1'b0,1'b0,4'hF,16'h0000,16'h0042,4'd6},  // R6
    '{1'b1,1'b0,4'hF,16'h0041,16'h0000,4'd5},
    '{1'b1,1'b0,4'hE,16'h00FE,16'h0000,4'd5},
    '{1'b0,1'b1,4'hC,16'h0000,16'h55AA,4'd5},  // R5 word read
    '{1'b0,1'b0,4'hE,16'h0000,16'h0000,4'd6},  // R6 step 2
    '{1'b1,1'b0,4'hF,16'h0041,16'h0000,4'd11},
    '{1'b1,1'b0,4'hE,16'h00FF,16'h0000,4'd11},
    '{1'b0,1'b1,4'hC,16'h0000,16'h55AA,4'd11}, // R11 odd ptr
    '{1'b0,1'b0,4'hE,16'h0000,16'h0001,4'd11}, // R11 1FF+2
    '{1'b1,1'b0,4'hF,16'h0007,16'h0000,4'd7},  // R7 aie off
    '{1'b1,1'b0,4'hE,16'h00FF,16'h0000,4'd7},
    '{1'b1,1'b0,4'hC,16'h0033,16'h0000,4'd7},
    '{1'b0,1'b0,4'hE,16'h0000,16'h00FF,4'd7},  // R7 no step
    '{1'b0,1'b0,4'hC,16'h0000,16'h0033,4'd4},
    '{1'b1,1'b0,4'hF,16'h0047,16'h0000,4'd8},
    '{1'b0,1'b0,4'hC,16'h0000,16'h0033,4'd8},  // R8 7FF -> 000
    '{1'b0,1'b0,4'hE,16'h0000,16'h0000,4'd8},
    '{1'b0,1'b0,4'hF,16'h0000,16'h0040,4'd8},
    '{1'b1,1'b0,4'hF,16'h0047,16'h0000,4'd8},
    '{1'b1,1'b0,4'hE,16'h00FE,16'h0000,4'd8},
    '{1'b1,1'b1,4'hC,16'hBEEF,16'h0000,4'd8},  // R8 7FE+2 -> 000
    '{1'b0,1'b0,4'hF,16'h0000,16'h0040,4'd8},
    '{1'b1,1'b0,4'hF,16'h0047,16'h0000,4'd5},
    '{1'b1,1'b0,4'hE,16'h00FE,16'h0000,4'd5},
    '{1'b0,1'b0,4'hC,16'h0000,16'h00EF,4'd5},  // R5 low byte even
    '{1'b0,1'b0,4'hC,16'h0000,16'h00BE,4'd5},  // R5 high byte odd
    '{1'b1,1'b0,4'hD,16'h1234,16'h0000,4'd10},
    '{1'b1,1'b0,4'hA,16'h5678,16'h0000,4'd10},
    '{1'b0,1'b0,4'hD,16'h0000,16'h0000,4'd10}, // R10
    '{1'b0,1'b1,4'hD,16'h0000,16'h0000,4'd10},
    '{1'b0,1'b0,4'h0,16'h0000,16'h0000,4'd10},
    '{1'b0,1'b0,4'hE,16'h0000,16'h0000,4'd10},
    '{1'b0,1'b0,4'hF,16'h0000,16'h0040,4'd10},
    '{1'b1,1'b0,4'hF,16'h00FF,16'h0000,4'd2},
    '{1'b0,1'b0,4'hF,16'h0000,16'h0047,4'd2},  // R2 unused bits read 0
    '{1'b1,1'b0,4'hE,16'h00FE,16'h0000,4'd10},
    '{1'b0,1'b0,4'hC,16'h0000,16'h00EF,4'd10}  // R10 buffer untouched
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one strobe of one cycle; returns rdata sampled while strobe high
  task automatic access(input logic wr, input logic word, input logic [3:0] off,
                        input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; word_mode = word; host_addr = off; host_wdata = wd;
    @(posedge clk);
    #2 rd = host_rdata;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    host_sel = 1'b0; host_wr = 1'b0; word_mode = 1'b0; host_addr = '0; host_wdata = '0;
    do_reset();

    access(1'b0, 1'b0, 4'hE, 16'h0, rd); check(rd, 16'h0000, "R1 ptr low after reset");
    access(1'b0, 1'b0, 4'hF, 16'h0, rd); check(rd, 16'h0000, "R1 ptr high after reset");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].word, VEC[i].off, VEC[i].wd, rd);
      if (!VEC[i].wr) begin
        checks++;
        if (rd !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].req, i, rd, VEC[i].exp);
        end
      end
    end

    // R9: held strobe, pointer stays put, then exactly one step
    access(1'b1, 1'b0, 4'hF, 16'h0041, rd);
    access(1'b1, 1'b0, 4'hE, 16'h00FE, rd);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; word_mode = 1'b0; host_addr = 4'hC;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk);
      #2 check(host_rdata, 16'h00AA, "R9 held strobe data");
    end
    @(negedge clk) host_sel = 1'b0;
    access(1'b0, 1'b0, 4'hE, 16'h0, rd); check(rd, 16'h00FF, "R9 one step per strobe");

    // R1: reset in mid run clears pointer and enable
    do_reset();
    access(1'b0, 1'b0, 4'hE, 16'h0, rd); check(rd, 16'h0000, "R1 ptr low after second reset");
    access(1'b0, 1'b0, 4'hF, 16'h0, rd); check(rd, 16'h0000, "R1 ptr high after second reset");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule